// File: doc/BRIEF.md
# Two-Queue ADC Conversion Sequencer

This block is the digital sequencer in front of a 10-bit analog-to-digital converter. Software fills a table of 64 command slots. Each slot names an input channel. A boundary value divides the table between two queues. The first queue owns the slots below the boundary, and the second queue owns the slots from the boundary up to the top of the table. Each queue runs through its own slots in order. For each slot it hands the channel to the converter over a request/response port. When the converter answers, the result is stored in the result slot with the same index.

Each queue has its own trigger mode: disabled, software start, rising edge on its external pin, or level gate on that pin. A shared interval timer can also start either queue or both. The first queue has priority. If it starts while the second queue is running, the second queue finishes its current conversion, waits, and then carries on from its next slot. Results can be read back in four views: right or left aligned, each either unsigned or offset-binary signed.

Top module: `qadc_seq`

## Requirements
- R1: After reset both queues are idle, every flag is clear, `conv_req` is low and both interrupt outputs are low.
- R2: Writing address 0x000+n stores the low 6 bits of write data as the command of slot n, and reading that address returns it. The code 63 marks end of queue, and channels 0 to 39 are valid.
- R3: Queue 1 converts slots 0 up to boundary-1 and queue 2 converts slots from the boundary up to 63. Slots are converted in ascending order, and `conv_ch` carries the slot's channel.
- R4: The converter's answer for slot n is stored at result n. Reading 0x100+n returns it zero-extended to 16 bits.
- R5: Reading 0x140+n returns the result with its MSB inverted and sign-extended. 0x180+n returns the result in bits 15:6 with zeros below. 0x1C0+n returns the MSB-inverted result in bits 15:6.
- R6: A slot holding code 63, or reaching the end of the queue's range, ends the queue without a conversion. This sets the queue's completion flag (status bit 0 for queue 1, bit 2 for queue 2) and clears its active bit (status bit 4 or 5).
- R7: Control register 0x040 holds the boundary [5:0], the queue 1 mode [7:6] and the queue 2 mode [9:8], with modes 0 off, 1 software, 2 edge and 3 gate. Writing 0x042 bit 0 or bit 1 starts queue 1 or queue 2 only if that queue is in software mode.
- R8: In edge mode a rising edge on the queue's trigger pin starts the queue from its first slot. Holding the pin high does not start it again.
- R9: In gate mode the queue runs while its pin is high and restarts from its first slot each time it ends. When the pin goes low, the current conversion finishes, then the queue stops and sets its pause flag (status bit 1 or 3).
- R10: With a non-zero period P in register 0x041, the timer fires every P cycles after the period is written. Each tick starts queue 1 if control bit 10 is set and queue 2 if control bit 11 is set, provided the queue's mode is not off.
- R11: A queue 1 start while queue 2 is active sets queue 2's pause flag. Queue 2's current conversion finishes, queue 1 runs to its end, then queue 2 resumes at its next slot.
- R12: `irq_q1` is high while a queue 1 flag is set with its enable (register 0x044 bit 0 for completion, bit 1 for pause). `irq_q2` works the same way with bits 2 and 3. Writing 1s to status register 0x043 clears the matching flags.
- R13: `conv_req` stays high with a stable `conv_ch` until `conv_done` is seen. Only one conversion is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 9 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data for bus_addr |
| trig1 | input | 1 | Queue 1 edge/gate pin |
| trig2 | input | 1 | Queue 2 edge/gate pin |
| conv_req | output | 1 | Conversion request |
| conv_ch | output | 6 | Channel to convert |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 10 | Converter result |
| irq_q1 | output | 1 | Queue 1 interrupt |
| irq_q2 | output | 1 | Queue 2 interrupt |

## Verification
The bench targets the orderings where a wrong sequencer gives a different channel stream. In a queue 1 preemption of queue 2, a design that aborts or restarts queue 2 would repeat or skip its channels, and one that ignores priority would not interleave them. The bench drops a gate in the middle of a queue and holds an edge pin high: a design that confuses gate with edge either keeps rescanning or never stops with a pause flag. Results at mid-scale and at both extremes are read in all four views, which exposes a wrong MSB inversion or a wrong shift. An end-of-queue code placed before the boundary catches a queue that runs past it.

// File: rtl/qadc_seq.sv
module qadc_seq #(
  parameter int NSLOT = 64,
  parameter int CHW   = 6,
  parameter int RESW  = 10,
  parameter int DW    = 16,
  parameter int AW    = 9,
  parameter int TMRW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  output logic [DW-1:0]   bus_rdata,
  input  logic            trig1,
  input  logic            trig2,
  output logic            conv_req,
  output logic [CHW-1:0]  conv_ch,
  input  logic            conv_done,
  input  logic [RESW-1:0] conv_data,
  output logic            irq_q1,
  output logic            irq_q2
);
  localparam int SW  = $clog2(NSLOT);
  localparam int PAD = DW - RESW;
  localparam logic [CHW-1:0] EOQ = '1;
  typedef enum logic [1:0] {M_OFF, M_SOFT, M_EDGE, M_GATE} mode_t;

  logic [CHW-1:0]  cmd [NSLOT];
  logic [RESW-1:0] res [NSLOT];
  logic [SW-1:0]   bnd, cur_slot;
  mode_t           mode1, mode2;
  logic            tmr1, tmr2, act1, act2, busy, cur_q, trig1_q, trig2_q;
  logic [TMRW-1:0] per, tcnt;
  logic [3:0]      flg, ien;
  logic [SW:0]     ptr1, ptr2;

  wire ctl_sel = bus_addr[AW-1:SW] == 3'b001;
  wire wr_ctrl = bus_we && ctl_sel && bus_addr[SW-1:0] == 0;
  wire wr_per  = bus_we && ctl_sel && bus_addr[SW-1:0] == 1;
  wire wr_go   = bus_we && ctl_sel && bus_addr[SW-1:0] == 2;
  wire wr_stat = bus_we && ctl_sel && bus_addr[SW-1:0] == 3;
  wire wr_ien  = bus_we && ctl_sel && bus_addr[SW-1:0] == 4;

  wire tick = (per != 0) && (tcnt == per - 1'b1);
  wire start1 = (mode1 == M_SOFT && wr_go && bus_wdata[0]) || (mode1 == M_EDGE && trig1 && !trig1_q) ||
                (mode1 == M_GATE && trig1) || (mode1 != M_OFF && tmr1 && tick);
  wire start2 = (mode2 == M_SOFT && wr_go && bus_wdata[1]) || (mode2 == M_EDGE && trig2 && !trig2_q) ||
                (mode2 == M_GATE && trig2) || (mode2 != M_OFF && tmr2 && tick);

  wire          sel_q    = !act1;
  wire [SW:0]   sel_ptr  = act1 ? ptr1 : ptr2;
  wire [SW:0]   sel_end  = act1 ? {1'b0, bnd} : (SW+1)'(NSLOT);
  wire          sel_halt = act1 ? (mode1 == M_GATE && !trig1) : (mode2 == M_GATE && !trig2);
  wire          sel_eoq  = (sel_ptr == sel_end) || (cmd[sel_ptr[SW-1:0]] == EOQ);

  always_ff @(posedge clk) begin
    if (bus_we && bus_addr[AW-1:SW] == 3'b000) cmd[bus_addr[SW-1:0]] <= bus_wdata[CHW-1:0];
    if (busy && conv_done) res[cur_slot] <= conv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd <= '0; mode1 <= M_OFF; mode2 <= M_OFF; tmr1 <= 1'b0; tmr2 <= 1'b0;
      per <= '0; tcnt <= '0; flg <= '0; ien <= '0; act1 <= 1'b0; act2 <= 1'b0;
      ptr1 <= '0; ptr2 <= '0; busy <= 1'b0; cur_q <= 1'b0; cur_slot <= '0;
      conv_ch <= '0; trig1_q <= 1'b0; trig2_q <= 1'b0;
    end else begin
      trig1_q <= trig1;
      trig2_q <= trig2;
      if (wr_ctrl) begin
        bnd <= bus_wdata[SW-1:0];
        mode1 <= mode_t'(bus_wdata[7:6]);
        mode2 <= mode_t'(bus_wdata[9:8]);
        tmr1 <= bus_wdata[10];
        tmr2 <= bus_wdata[11];
      end
      if (wr_ien) ien <= bus_wdata[3:0];
      if (wr_per) begin per <= bus_wdata[TMRW-1:0]; tcnt <= '0; end
      else if (per == 0 || tick) tcnt <= '0;
      else tcnt <= tcnt + 1'b1;
      if (wr_stat) flg <= flg & ~bus_wdata[3:0];

      if (busy) begin
        if (conv_done) begin
          busy <= 1'b0;
          if (cur_q) ptr2 <= ptr2 + 1'b1;
          else ptr1 <= ptr1 + 1'b1;
        end
      end else if (act1 || act2) begin
        if (sel_halt) begin
          if (sel_q) begin act2 <= 1'b0; flg[3] <= 1'b1; end
          else begin act1 <= 1'b0; flg[1] <= 1'b1; end
        end else if (sel_eoq) begin
          if (sel_q) begin act2 <= 1'b0; flg[2] <= 1'b1; end
          else begin act1 <= 1'b0; flg[0] <= 1'b1; end
        end else begin
          busy <= 1'b1;
          cur_q <= sel_q;
          cur_slot <= sel_ptr[SW-1:0];
          conv_ch <= cmd[sel_ptr[SW-1:0]];
        end
      end

      if (start1 && !act1) begin
        act1 <= 1'b1;
        ptr1 <= '0;
        if (act2) flg[3] <= 1'b1;
      end
      if (start2 && !act2) begin
        act2 <= 1'b1;
        ptr2 <= {1'b0, bnd};
      end
    end
  end

  assign conv_req = busy;
  assign irq_q1 = (flg[0] & ien[0]) | (flg[1] & ien[1]);
  assign irq_q2 = (flg[2] & ien[2]) | (flg[3] & ien[3]);

  wire [RESW-1:0] rres = res[bus_addr[SW-1:0]];
  wire [RESW-1:0] sres = {~rres[RESW-1], rres[RESW-2:0]};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr[AW-1:SW])
      3'b000: bus_rdata = DW'(cmd[bus_addr[SW-1:0]]);
      3'b001: case (bus_addr[SW-1:0])
        0: bus_rdata = DW'({tmr2, tmr1, mode2, mode1, bnd});
        1: bus_rdata = DW'(per);
        3: bus_rdata = DW'({act2, act1, flg});
        4: bus_rdata = DW'(ien);
        default: bus_rdata = '0;
      endcase
      3'b100: bus_rdata = {{PAD{1'b0}}, rres};
      3'b101: bus_rdata = {{PAD{sres[RESW-1]}}, sres};
      3'b110: bus_rdata = {rres, {PAD{1'b0}}};
      3'b111: bus_rdata = {sres, {PAD{1'b0}}};
      default: bus_rdata = '0;
    endcase
  end

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req && $stable(conv_ch));
  a_r6_no_eoq_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> conv_ch != EOQ);
  a_r11_owner_active: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (cur_q ? act2 : act1));
  a_r12_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q1) |-> (ien[0] || ien[1]));
  a_r13_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_done |=> !conv_req);
endmodule

// File: tb/qadc_seq_tb.sv
module qadc_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic [15:0] bus_rdata;
  logic trig1 = 1'b0, trig2 = 1'b0;
  logic conv_req, conv_done = 1'b0;
  logic [5:0] conv_ch;
  logic [9:0] conv_data = '0;
  logic irq_q1, irq_q2;

  int checks = 0, failures = 0, nlog = 0, cnt = 0;
  bit finished = 0;
  logic [5:0] lg [0:255];
  localparam int LAT = 4;

  // channel, right unsigned, right signed, left unsigned, left signed (converter answers {ch,4'h9})
  localparam logic [69:0] VEC [5] = '{
    {6'd0,  16'h0009, 16'hFE09, 16'h0240, 16'h8240},
    {6'd39, 16'h0279, 16'h0079, 16'h9E40, 16'h1E40},
    {6'd31, 16'h01F9, 16'hFFF9, 16'h7E40, 16'hFE40},
    {6'd32, 16'h0209, 16'h0009, 16'h8240, 16'h0240},
    {6'd5,  16'h0059, 16'hFE59, 16'h1640, 16'h9640}
  };

  qadc_seq u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .trig1(trig1), .trig2(trig2),
    .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
    .irq_q1(irq_q1), .irq_q2(irq_q2));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) cnt <= 0;
    else if (conv_req && !conv_done) begin
      if (cnt == LAT) begin
        conv_done <= 1'b1;
        conv_data <= {conv_ch, 4'h9};
        lg[nlog[7:0]] <= conv_ch;
        nlog <= nlog + 1;
        cnt <= 0;
      end else cnt <= cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_stat(input logic [15:0] mask, input logic [15:0] val);
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(9'h043, s);
      if ((s & mask) == val) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n0, n1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(9'h043, d); check("R1 status", d, 16'h0);
    check("R1 conv_req", conv_req, 1'b0);
    check("R1 irq", {irq_q1, irq_q2}, 2'b00);

    for (int i = 0; i < 5; i++) wr(9'(i), 16'(VEC[i][69:64]));
    wr(9'h005, 16'd63);
    rd(9'h001, d); check("R2 slot1", d, 16'd39);
    rd(9'h005, d); check("R2 eoq slot", d, 16'd63);

    wr(9'h040, 16'h004A);
    n0 = nlog;
    wr(9'h042, 16'h1);
    wait_stat(16'h0001, 16'h0001);
    check("R6 stop at eoq count", nlog - n0, 5);
    rd(9'h043, d); check("R6 q1 idle and done", d & 16'h31, 16'h01);
    for (int i = 0; i < 5; i++) begin
      check("R3 order", lg[n0 + i], VEC[i][69:64]);
      rd(9'h100 + 9'(i), d); check("R4 right unsigned", d, VEC[i][63:48]);
      rd(9'h140 + 9'(i), d); check("R5 right signed", d, VEC[i][47:32]);
      rd(9'h180 + 9'(i), d); check("R5 left unsigned", d, VEC[i][31:16]);
      rd(9'h1C0 + 9'(i), d); check("R5 left signed", d, VEC[i][15:0]);
    end

    check("R12 masked", irq_q1, 1'b0);
    wr(9'h044, 16'h1);
    @(negedge clk); check("R12 enabled", irq_q1, 1'b1);
    wr(9'h043, 16'h1);
    @(negedge clk); check("R12 cleared", irq_q1, 1'b0);
    rd(9'h043, d); check("R12 flag clear", d & 16'h1, 16'h0);
    wr(9'h044, 16'h0);

    wr(9'h040, 16'h000A);
    n0 = nlog;
    wr(9'h042, 16'h1);
    repeat (20) @(negedge clk);
    check("R7 off mode ignores start", nlog - n0, 0);
    rd(9'h043, d); check("R7 stays idle", d & 16'h30, 16'h0);

    wr(9'h00A, 16'd20); wr(9'h00B, 16'd21); wr(9'h00C, 16'd22); wr(9'h00D, 16'd63);
    wr(9'h040, 16'h020A);
    n0 = nlog;
    @(negedge clk); trig2 = 1'b1;
    repeat (2) @(negedge clk); trig2 = 1'b0;
    wait_stat(16'h0004, 16'h0004);
    check("R8 edge run count", nlog - n0, 3);
    check("R3 q2 first", lg[n0], 6'd20);
    check("R3 q2 last", lg[n0 + 2], 6'd22);
    wr(9'h043, 16'hF);
    n0 = nlog;
    @(negedge clk); trig2 = 1'b1;
    wait_stat(16'h0004, 16'h0004);
    repeat (40) @(negedge clk);
    check("R8 held high runs once", nlog - n0, 3);
    trig2 = 1'b0;
    wr(9'h043, 16'hF);

    wr(9'h000, 16'd1); wr(9'h001, 16'd2); wr(9'h002, 16'd63);
    wr(9'h040, 16'h014A);
    n0 = nlog;
    wr(9'h042, 16'h2);
    for (int i = 0; i < 50 && !conv_req; i++) @(negedge clk);
    d = {10'd0, conv_ch};
    @(negedge clk);
    check("R13 req held", conv_req, 1'b1);
    check("R13 channel stable", conv_ch, d[5:0]);
    wr(9'h042, 16'h1);
    wait_stat(16'h0004, 16'h0004);
    check("R11 count", nlog - n0, 5);
    check("R11 q2 slot0", lg[n0], 6'd20);
    check("R11 q1 first", lg[n0 + 1], 6'd1);
    check("R11 q1 second", lg[n0 + 2], 6'd2);
    check("R11 q2 resumes", lg[n0 + 3], 6'd21);
    check("R11 q2 last", lg[n0 + 4], 6'd22);
    rd(9'h043, d); check("R11 flags", d & 16'hF, 16'hD);
    wr(9'h043, 16'hF);

    for (int i = 0; i < 8; i++) wr(9'(i), 16'(i));
    wr(9'h040, 16'h00C8);
    n0 = nlog;
    @(negedge clk); trig1 = 1'b1;
    for (int i = 0; i < 200 && nlog < n0 + 2; i++) @(negedge clk);
    trig1 = 1'b0;
    wait_stat(16'h0010, 16'h0000);
    rd(9'h043, d); check("R9 paused not done", d & 16'h3, 16'h2);
    check("R9 stopped early", (nlog - n0) < 8, 1'b1);
    wr(9'h043, 16'hF);
    n1 = nlog;
    @(negedge clk); trig1 = 1'b1;
    wait_stat(16'h0001, 16'h0001);
    trig1 = 1'b0;
    wait_stat(16'h0010, 16'h0000);
    check("R9 restart from first slot", lg[n1], 6'd0);
    check("R9 runs to end", lg[n1 + 7], 6'd7);
    wr(9'h043, 16'hF);

    wr(9'h040, 16'h090A);
    n0 = nlog;
    wr(9'h041, 16'd50);
    repeat (30) @(negedge clk);
    check("R10 no tick yet", nlog - n0, 0);
    repeat (110) @(negedge clk);
    check("R10 two ticks", nlog - n0, 6);
    wr(9'h041, 16'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule